// File: doc/BRIEF.md
# Two-Channel Trace Pixel Comparator

This block draws two stored waveforms on a raster display. While the display is showing the captured traces, it steps a read address through two 256-entry sample memories in time with the pixel clock. Each cycle it compares the sample read from each memory with the number of the raster line being drawn. Wherever a channel's stored sample equals the line number, the pixel for that channel lights. Channel 1 lights the green gun and channel 2 lights the red gun.

The read address is reloaded at every line sync with a fixed non-zero start value, by default 8. This lines the trigger sample up with the leftmost vertical grid line. Horizontal zoom comes from how often the address advances: every pixel clock, every second clock or every fourth clock. With a 4 MHz pixel clock these rates are 4, 2 and 1 MHz. Both traces are dark while a capture is being recorded and during the line sync pulse. The memories are treated as asynchronous reads, so the data for the current address arrives within the same cycle. The comparison result is registered, so each pixel appears one clock after its address.

Top module: `trace_pixel_cmp`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `rd_addr_o` is 8 (parameter `START_ADDR`) and `green_o` and `red_o` are both 0.
- R2: A cycle with `hsync_i` high loads `rd_addr_o` with 8 at the next clock edge, whatever the zoom code is. It also restarts the advance phase, so the first step after the sync comes a full step period later.
- R3: When `hsync_i` is low, `zoom_sel_i` sets how often `rd_addr_o` advances by one. Code 0 advances on every clock. Code 1 advances on every second clock. Codes 2 and 3 both advance on every fourth clock.
- R4: `rd_addr_o` wraps from 255 to 0 and keeps counting. The next line sync still loads 8.
- R5: `green_o` is 1 in the cycle after a cycle in which `ch1_rd_data_i` equals `line_num_i` in all 8 bits while `rec_busy_i` and `hsync_i` are both low.
- R6: `red_o` follows the same rule as R5, using `ch2_rd_data_i`. It does not depend on channel 1.
- R7: A sample that differs from the line number in any bit gives a 0 on that channel's pixel output in the following cycle. Only the equality result is used.
- R8: A cycle with `rec_busy_i` high gives 0 on both pixel outputs in the following cycle, even when a sample matches the line number.
- R9: A cycle with `hsync_i` high gives 0 on both pixel outputs in the following cycle, even when a sample matches the line number.
- R10: `rd_en_o` is the inverse of `rec_busy_i` within the same cycle. The memories are held in read mode for as long as the display is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (4 MHz base rate) |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_i | input | 1 | Line sync pulse, active high |
| line_num_i | input | 8 | Number of the raster line being drawn |
| zoom_sel_i | input | 2 | Zoom code: 0 = every clock, 1 = every 2nd clock, 2 or 3 = every 4th clock |
| rec_busy_i | input | 1 | High while a capture is being recorded |
| ch1_rd_data_i | input | 8 | Channel 1 memory read data for `rd_addr_o` |
| ch2_rd_data_i | input | 8 | Channel 2 memory read data for `rd_addr_o` |
| rd_addr_o | output | 8 | Shared read address for both sample memories |
| rd_en_o | output | 1 | Memory read enable, high while the display is running |
| green_o | output | 1 | Channel 1 trace pixel |
| red_o | output | 1 | Channel 2 trace pixel |

## Verification
Three events can fall in the same cycle: a line sync, an exact sample match, and the address reload with its restart of the zoom phase. The bench provokes this by starting a new line with the line number set to the value the channel 1 memory returns at the current address. That cycle must give a dark pixel, and the address must reload to 8 rather than advance. A recording pulse is placed over a matching sample to check the same thing for recording. A line long enough to wrap the address past 255 is followed by a sync, to show that the reload does not depend on the wrap.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    // Zoom codes: how many pixel clocks each sample occupies.
    typedef enum logic [1:0] {
        ZOOM_X1  = 2'd0,
        ZOOM_X2  = 2'd1,
        ZOOM_X4  = 2'd2,
        ZOOM_X4B = 2'd3
    } zoom_e;

    localparam int unsigned SMP_W   = 8;
    localparam int unsigned PHASE_W = 2;

endpackage

// File: rtl/tpc_rate_div.sv
module tpc_rate_div
    import tpc_pkg::*;
#(
    parameter int unsigned PH_W = PHASE_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] zoom_i,
    output logic       step_o
);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } div_st_t;

    div_st_t         st_d, st_q;
    logic [PH_W-1:0] limit;

    always_comb begin
        case (zoom_e'(zoom_i))
            ZOOM_X1: limit = '0;
            ZOOM_X2: limit = PH_W'(1);
            default: limit = '1;
        endcase
        step_o = !sync_i && (st_q.phase >= limit);
        st_d   = st_q;
        if (sync_i || step_o) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R3: a step at a slowed zoom code is never followed directly by another step
    a_r3_step_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !sync_i && zoom_i != 2'd0) |=> (zoom_i == 2'd0 || !step_o));

endmodule

// File: rtl/tpc_addr_ctr.sv
module tpc_addr_ctr #(
    parameter int unsigned AW         = 8,
    parameter int unsigned START_ADDR = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);

    localparam logic [AW-1:0] START_V = AW'(START_ADDR);
    localparam logic [AW-1:0] LAST_V  = '1;

    typedef struct packed {
        logic [AW-1:0] addr;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_i) begin
            st_d.addr = START_V;
        end else if (step_i) begin
            st_d.addr = st_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.addr <= START_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o = st_q.addr;

    // R2: a line sync reloads the start address
    a_r2_sync_reload: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (addr_o == START_V));

    // R3: no step and no sync keeps the address where it is
    a_r3_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && !step_i) |=> $stable(addr_o));

    // R4: stepping from the top address wraps to zero
    a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_i && step_i && addr_o == LAST_V) |=> (addr_o == '0));

endmodule

// File: rtl/tpc_chan_cmp.sv
module tpc_chan_cmp #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] sample_i,
    input  logic [DW-1:0] line_i,
    input  logic          blank_i,
    output logic          pix_o
);

    typedef struct packed {
        logic pix;
    } cmp_st_t;

    cmp_st_t st_d, st_q;

    always_comb begin
        st_d.pix = (sample_i == line_i) && !blank_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix_o = st_q.pix;

    // R5/R6: an exact match outside blanking lights the pixel next cycle
    a_r5_match_lights: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i == line_i && !blank_i) |=> pix_o);

    // R7: any differing bit leaves the pixel dark next cycle
    a_r7_miss_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i != line_i) |=> !pix_o);

endmodule

// File: rtl/trace_pixel_cmp.sv
module trace_pixel_cmp
    import tpc_pkg::*;
#(
    parameter int unsigned AW         = 8,
    parameter int unsigned DW         = SMP_W,
    parameter int unsigned START_ADDR = 8,
    parameter int unsigned NCH        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_i,
    input  logic [DW-1:0] line_num_i,
    input  logic [1:0]    zoom_sel_i,
    input  logic          rec_busy_i,
    input  logic [DW-1:0] ch1_rd_data_i,
    input  logic [DW-1:0] ch2_rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          rd_en_o,
    output logic          green_o,
    output logic          red_o
);

    logic          step;
    logic          blank;
    logic [DW-1:0] smp [NCH];
    logic [NCH-1:0] pix;

    assign smp[0] = ch1_rd_data_i;
    assign smp[1] = ch2_rd_data_i;
    assign blank  = rec_busy_i || hsync_i;
    assign rd_en_o = !rec_busy_i;

    tpc_rate_div #(.PH_W(PHASE_W)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (hsync_i),
        .zoom_i (zoom_sel_i),
        .step_o (step)
    );

    tpc_addr_ctr #(.AW(AW), .START_ADDR(START_ADDR)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (hsync_i),
        .step_i (step),
        .addr_o (rd_addr_o)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        tpc_chan_cmp #(.DW(DW)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (smp[c]),
            .line_i   (line_num_i),
            .blank_i  (blank),
            .pix_o    (pix[c])
        );
    end

    assign green_o = pix[0];
    assign red_o   = pix[1];

    // R8: recording darkens both traces on the next cycle
    a_r8_rec_blank: assert property (@(posedge clk) disable iff (!rst_n)
        rec_busy_i |=> (!green_o && !red_o));

    // R9: line sync darkens both traces on the next cycle
    a_r9_sync_blank: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_i |=> (!green_o && !red_o));

endmodule

// File: tb/sim_trace_pixel_cmp.sv
module sim_trace_pixel_cmp;

    localparam int START = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync = 1'b0;
    logic [7:0] line_num = 8'd0;
    logic [1:0] zoom = 2'd0;
    logic       rec = 1'b0;
    logic [7:0] d1, d2;
    logic [7:0] rd_addr;
    logic       rd_en, green, red;

    logic [7:0] mem1 [256];
    logic [7:0] mem2 [256];

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int ref_addr = START;
    int ref_cnt  = 0;
    bit exp_g    = 0;
    bit exp_r    = 0;

    always #4 clk = ~clk;

    assign d1 = mem1[rd_addr];
    assign d2 = mem2[rd_addr];

    trace_pixel_cmp u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .hsync_i       (hsync),
        .line_num_i    (line_num),
        .zoom_sel_i    (zoom),
        .rec_busy_i    (rec),
        .ch1_rd_data_i (d1),
        .ch2_rd_data_i (d2),
        .rd_addr_o     (rd_addr),
        .rd_en_o       (rd_en),
        .green_o       (green),
        .red_o         (red)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare on every falling edge, then advance the model
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk(rd_addr == 8'(START), "R1 reset address", int'(rd_addr), START);
                chk(!green && !red, "R1 reset pixels", int'({green, red}), 0);
                ref_addr = START;
                ref_cnt  = 0;
                exp_g    = 0;
                exp_r    = 0;
            end else begin
                int per;
                chk(int'(rd_addr) == ref_addr, "R2 R3 R4 address", int'(rd_addr), ref_addr);
                chk(green == exp_g, "R5 R7 R8 R9 green", int'(green), int'(exp_g));
                chk(red == exp_r, "R6 R7 R8 R9 red", int'(red), int'(exp_r));
                chk(rd_en == !rec, "R10 read enable", int'(rd_en), int'(!rec));
                exp_g = (mem1[rd_addr] == line_num) && !rec && !hsync;
                exp_r = (mem2[rd_addr] == line_num) && !rec && !hsync;
                per = (zoom == 2'd0) ? 1 : (zoom == 2'd1) ? 2 : 4;
                if (hsync) begin
                    ref_addr = START;
                    ref_cnt  = 0;
                end else if (ref_cnt >= per - 1) begin
                    ref_cnt  = 0;
                    ref_addr = (ref_addr + 1) % 256;
                end else begin
                    ref_cnt++;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run_line(input logic [1:0] z, input int n, input logic [7:0] ln);
        hsync = 1'b1;
        zoom = z;
        tick();
        hsync = 1'b0;
        line_num = ln;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            mem1[a] = 8'(a);
            mem2[a] = 8'((a * 3) % 256);
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R3 code 0, R5 green at address 20, R6 red where 3a matches
        run_line(2'd0, 30, 8'd20);
        run_line(2'd0, 30, 8'd45);
        // R3 slower codes
        run_line(2'd1, 40, 8'd30);
        run_line(2'd2, 50, 8'd12);
        run_line(2'd3, 50, 8'd10);
        // R8 recording pulse over the matching sample
        hsync = 1'b1; zoom = 2'd0; tick();
        hsync = 1'b0; line_num = 8'd14;
        for (int i = 0; i < 20; i++) begin
            rec = (i >= 4 && i <= 8);
            tick();
        end
        rec = 1'b0;
        // R9 sync coinciding with a match: line number equals current sample
        line_num = mem1[rd_addr];
        run_line(2'd0, 10, 8'd9);
        line_num = mem1[rd_addr];
        run_line(2'd1, 10, 8'd3);
        // R4 wrap past 255 then reload
        run_line(2'd0, 300, 8'd5);
        run_line(2'd0, 12, 8'd10);
        // zoom change in mid-line
        run_line(2'd2, 6, 8'd16);
        zoom = 2'd1;
        for (int i = 0; i < 12; i++) tick();
        zoom = 2'd0;
        for (int i = 0; i < 12; i++) tick();
        run_line(2'd0, 5, 8'd8);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule